// File: doc/BRIEF.md
# Flash Program/Erase Busy Status Engine

This block sits behind the command decoder of a parallel NOR flash model. It carries out the long internal operations: writing a byte, erasing one sector, and erasing the whole array. The decoder hands it a single-cycle start pulse together with a target address and a data byte. The engine then holds a busy flag for a fixed number of clock cycles, set by a parameter. When that count runs out it applies the result to a small byte array held in registers.

While an operation runs, read accesses do not return plain array data. They return progress information. Bit 6 alternates on each successive read. During a byte write, bit 7 at the target address reads as the inverse of the bit being written. A system can poll either bit to find out when the operation has finished. A chip erase leaves the boot sector alone while the boot lock is set. The same lock turns a sector erase aimed at the boot sector into a short no-op.

A separate active-low halt input works like the device's reset pin. It abandons the running operation without touching the array, and it keeps the data outputs undriven while it is low.

Top module: `flash_busy_engine`

## Requirements
- R1: After `rst_n` is released, every byte reads 0xFF, `busy` is low and `rd_drive` is low.
- R2: A write started by `prog_go` raises `busy` for exactly PROG_CYC cycles. When it ends, the byte at `op_addr` holds its old value AND `op_data`, so bits can only go from 1 to 0.
- R3: While a write is busy, a read of its target address returns the inverse of bit 7 of the written data on `rd_data[7]`.
- R4: While any operation is busy, `rd_data[6]` is 0 on the first read after the start and inverts on each later read. Bits 5..0, and bit 7 at any address that is not a write target, come from the array. Once the engine is idle, reads return true array data.
- R5: A sector erase raises `busy` for exactly ERASE_CYC cycles. It then sets to 0xFF every byte whose upper address bits (`addr[ADDR_W-1:SECT_W]`) match those of `op_addr`. Other sectors are not changed.
- R6: With `boot_lock` high, a sector erase aimed at sector 0 (the boot sector) raises `busy` for SKIP_CYC cycles and changes nothing.
- R7: A chip erase raises `busy` for exactly ERASE_CYC cycles. It sets every byte to 0xFF, except that sector 0 is kept when `boot_lock` was high at the start.
- R8: Start pulses that arrive while `busy` is high, including during a chip erase, are ignored and leave no trace in the array.
- R9: While `halt_n` is low, `busy` is low from the next cycle on, no read is answered (`rd_drive` low), and the interrupted operation leaves the array unchanged. After `halt_n` returns high, reads and new operations work normally.
- R10: A read request on `rd_en` is answered on the next cycle, with `rd_drive` high for one cycle and the data on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; fills the array with 0xFF |
| halt_n | input | 1 | Active-low halt: aborts the operation and blocks outputs |
| prog_go | input | 1 | Start pulse for a byte write |
| serase_go | input | 1 | Start pulse for a sector erase |
| cerase_go | input | 1 | Start pulse for a chip erase |
| op_addr | input | ADDR_W | Target address of the started operation |
| op_data | input | 8 | Data byte for a write |
| boot_lock | input | 1 | Boot sector protection, sampled at start |
| rd_en | input | 1 | Read request |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Read result |
| rd_drive | output | 1 | High when rd_data is driven (output enable) |
| busy | output | 1 | Operation in progress |

## Verification
The bench builds the engine with a 64-byte array in eight 8-byte sectors. It uses PROG_CYC=12, ERASE_CYC=30 and SKIP_CYC=3. These short durations let it measure every busy window to the exact cycle. They also leave room for several status reads inside one write or erase, so the alternating bit and the inverted polling bit can be followed over a sequence. Because the sectors are small, the bench can seed bytes in the boot sector, in the erased sector and in a distant sector, and then confirm which of them survive each erase mode and each abort.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;
    typedef enum logic [2:0] {
        OP_NONE   = 3'd0,
        OP_PROG   = 3'd1,
        OP_SERASE = 3'd2,
        OP_CERASE = 3'd3,
        OP_SKIP   = 3'd4
    } op_kind_e;
endpackage

// File: rtl/op_timer.sv
module op_timer #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             busy,
    output logic             done
);
    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    tmr_s s_d, s_q;

    always_comb begin
        s_d  = s_q;
        done = s_q.busy && (s_q.cnt == '0) && halt_n;
        if (!halt_n) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (load) begin
            s_d.busy = 1'b1;
            s_d.cnt  = load_val;
        end else if (s_q.busy) begin
            if (s_q.cnt == '0) s_d.busy = 1'b0;
            else               s_d.cnt  = s_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;

    p_halt_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_n |=> !s_q.busy);

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.busy && s_q.cnt != '0 && halt_n && !load)
        |=> (s_q.busy && s_q.cnt == $past(s_q.cnt) - 1'b1));
endmodule

// File: rtl/cell_array.sv
module cell_array import flash_stat_pkg::*; #(
    parameter int ADDR_W = 6,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit,
    input  op_kind_e          kind,
    input  logic [ADDR_W-1:0] c_addr,
    input  logic [7:0]        c_data,
    input  logic              lock,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_byte
);
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int BOOT_BYTES = 1 << SECT_W;

    logic [DEPTH-1:0][7:0] mem_d, mem_q;
    logic [ADDR_W-1:0]     idx;

    always_comb begin
        mem_d = mem_q;
        idx   = '0;
        if (commit) begin
            case (kind)
                OP_PROG: mem_d[c_addr] = mem_q[c_addr] & c_data;
                OP_SERASE: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        idx = ADDR_W'(i);
                        if (idx[ADDR_W-1:SECT_W] == c_addr[ADDR_W-1:SECT_W])
                            mem_d[i] = 8'hFF;
                    end
                end
                OP_CERASE: begin
                    for (int i = 0; i < DEPTH; i++) begin
                        if (!(lock && i < BOOT_BYTES))
                            mem_d[i] = 8'hFF;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q <= '1;
        else        mem_q <= mem_d;
    end

    assign rd_byte = mem_q[rd_addr];

    p_prog_clears_only_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind == OP_PROG)
        |=> ((mem_q[$past(c_addr)] & ~$past(c_data)) == 8'h00));

    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(mem_q));

    p_boot_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && kind == OP_CERASE && lock) |=> $stable(mem_q[BOOT_BYTES-1:0]));
endmodule

// File: rtl/status_mux.sv
module status_mux (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_n,
    input  logic       start,
    input  logic       rd_en,
    input  logic       busy,
    input  logic       poll_hit,
    input  logic       poll_bit,
    input  logic [7:0] arr_byte,
    output logic [7:0] rd_data,
    output logic       rd_drive
);
    typedef struct packed {
        logic       tog;
        logic       drive;
        logic [7:0] data;
    } st_s;

    st_s s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.drive = 1'b0;
        if (start) s_d.tog = 1'b0;
        if (halt_n && rd_en) begin
            s_d.drive = 1'b1;
            if (busy) begin
                s_d.data = {poll_hit ? ~poll_bit : arr_byte[7], s_q.tog, arr_byte[5:0]};
                s_d.tog  = ~s_q.tog;
            end else begin
                s_d.data = arr_byte;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rd_data  = s_q.data;
    assign rd_drive = s_q.drive;

    p_no_drive_halt_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_n |=> !rd_drive);

    p_read_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && halt_n) |=> rd_drive);

    p_toggle_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && halt_n && busy && !start) |=> (s_q.tog != $past(s_q.tog)));
endmodule

// File: rtl/flash_busy_engine.sv
module flash_busy_engine import flash_stat_pkg::*; #(
    parameter int ADDR_W    = 6,
    parameter int SECT_W    = 3,
    parameter int PROG_CYC  = 8,
    parameter int ERASE_CYC = 24,
    parameter int SKIP_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_n,
    input  logic              prog_go,
    input  logic              serase_go,
    input  logic              cerase_go,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [7:0]        op_data,
    input  logic              boot_lock,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              rd_drive,
    output logic              busy
);
    localparam int MAX_A   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int MAX_CYC = (MAX_A > SKIP_CYC) ? MAX_A : SKIP_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        op_kind_e          kind;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic              lock;
    } op_s;

    op_s              op_d, op_q;
    logic             accept, load, done, busy_w;
    logic [CNT_W-1:0] load_val;
    logic [7:0]       arr_byte;
    logic             poll_hit;

    assign accept = halt_n && !busy_w && (prog_go || serase_go || cerase_go);

    always_comb begin
        op_d     = op_q;
        load     = 1'b0;
        load_val = '0;
        if (accept) begin
            op_d.addr = op_addr;
            op_d.data = op_data;
            op_d.lock = boot_lock;
            load      = 1'b1;
            if (prog_go) begin
                op_d.kind = OP_PROG;
                load_val  = CNT_W'(PROG_CYC - 1);
            end else if (serase_go) begin
                if (boot_lock && op_addr[ADDR_W-1:SECT_W] == '0) begin
                    op_d.kind = OP_SKIP;
                    load_val  = CNT_W'(SKIP_CYC - 1);
                end else begin
                    op_d.kind = OP_SERASE;
                    load_val  = CNT_W'(ERASE_CYC - 1);
                end
            end else begin
                op_d.kind = OP_CERASE;
                load_val  = CNT_W'(ERASE_CYC - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) op_q <= '{kind: OP_NONE, addr: '0, data: '0, lock: 1'b0};
        else        op_q <= op_d;
    end

    op_timer #(.CNT_W(CNT_W)) timer_i (
        .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .load(load),
        .load_val(load_val), .busy(busy_w), .done(done)
    );

    cell_array #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) array_i (
        .clk(clk), .rst_n(rst_n), .commit(done), .kind(op_q.kind),
        .c_addr(op_q.addr), .c_data(op_q.data), .lock(op_q.lock),
        .rd_addr(rd_addr), .rd_byte(arr_byte)
    );

    assign poll_hit = (op_q.kind == OP_PROG) && (rd_addr == op_q.addr);

    status_mux status_i (
        .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .start(load), .rd_en(rd_en),
        .busy(busy_w), .poll_hit(poll_hit), .poll_bit(op_q.data[7]),
        .arr_byte(arr_byte), .rd_data(rd_data), .rd_drive(rd_drive)
    );

    assign busy = busy_w;

    p_busy_ignores_go_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_w && (prog_go || serase_go || cerase_go)) |=> $stable(op_q));

    p_start_raises_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_n && !busy_w && (prog_go || serase_go || cerase_go)) |=> busy_w);
endmodule

// File: tb/flash_busy_engine_tb_top.sv
module flash_busy_engine_tb_top;
    localparam int CLK_PER = 10;
    localparam int AW = 6;
    localparam int PROG_C = 12;
    localparam int ERASE_C = 30;
    localparam int SKIP_C = 3;

    logic clk = 1'b0, rst_n = 1'b0, halt_n = 1'b1;
    logic prog_go = 0, serase_go = 0, cerase_go = 0, boot_lock = 0, rd_en = 0;
    logic [AW-1:0] op_addr = '0, rd_addr = '0;
    logic [7:0] op_data = '0, rd_data;
    logic rd_drive, busy;

    int total = 0, bad = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #(CLK_PER/2) clk = ~clk;

    flash_busy_engine #(.ADDR_W(AW), .SECT_W(3), .PROG_CYC(PROG_C),
                        .ERASE_CYC(ERASE_C), .SKIP_CYC(SKIP_C)) dut_i (
        .clk(clk), .rst_n(rst_n), .halt_n(halt_n), .prog_go(prog_go),
        .serase_go(serase_go), .cerase_go(cerase_go), .op_addr(op_addr),
        .op_data(op_data), .boot_lock(boot_lock), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_drive(rd_drive), .busy(busy)
    );

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read results as the design answers (R10)
    always @(negedge clk) begin
        if (rd_drive) begin
            if (exp_q.size() == 0) begin
                check("R10/R9 unexpected drive", 1, 0);
            end else begin
                automatic logic [7:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, rd_data, e);
            end
        end
    end

    task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic start(input int kind, input logic [AW-1:0] a, input logic [7:0] d);
        @(negedge clk);
        op_addr = a; op_data = d;
        prog_go = (kind == 0); serase_go = (kind == 1); cerase_go = (kind == 2);
        @(negedge clk);
        prog_go = 0; serase_go = 0; cerase_go = 0;
    endtask

    task automatic busy_len(output int n);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        check("watchdog", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", busy, 0);
        check("R1 drive after reset", rd_drive, 0);
        rd(0, 8'hFF, "R1 addr0");
        rd(63, 8'hFF, "R1 addr63");

        // R3/R4 polling during a write of 0xBC to address 10
        start(0, 10, 8'hBC);
        rd(10, 8'h3F, "R3 first poll");
        rd(20, 8'hFF, "R4 second read toggles");
        rd(10, 8'h3F, "R3 third poll");
        wait_idle();
        rd(10, 8'hBC, "R2 written value");
        rd(10, 8'hBC, "R4 idle no toggle");

        // R2 AND behaviour and exact duration
        start(0, 10, 8'h0F);
        busy_len(n);
        check("R2 program length", n, PROG_C);
        rd(10, 8'h0C, "R2 AND result");

        start(0, 2, 8'h55);  wait_idle();
        start(0, 40, 8'h11); wait_idle();
        start(0, 8, 8'h00);  wait_idle();

        // R5 sector erase of sector 1
        start(1, 13, 8'h00);
        busy_len(n);
        check("R5 erase length", n, ERASE_C);
        rd(10, 8'hFF, "R5 sector byte 10");
        rd(8, 8'hFF, "R5 sector byte 8");
        rd(2, 8'h55, "R5 boot untouched");
        rd(40, 8'h11, "R5 far sector untouched");

        // R6 locked boot sector erase skipped
        boot_lock = 1'b1;
        start(1, 3, 8'h00);
        busy_len(n);
        check("R6 skip length", n, SKIP_C);
        rd(2, 8'h55, "R6 boot kept");

        // R7/R8 locked chip erase, with toggle reads and ignored starts
        start(2, 0, 8'h00);
        rd(2, 8'h15, "R4 erase toggle 0");
        rd(2, 8'h55, "R4 erase toggle 1");
        start(0, 20, 8'h00);
        check("R8 still busy", busy, 1);
        wait_idle();
        rd(2, 8'h55, "R7 locked boot kept");
        rd(40, 8'hFF, "R7 erased");
        rd(20, 8'hFF, "R8 ignored write");

        // R7 unlocked chip erase
        boot_lock = 1'b0;
        start(2, 0, 8'h00);
        busy_len(n);
        check("R7 chip erase length", n, ERASE_C);
        rd(2, 8'hFF, "R7 boot erased unlocked");

        // R9 halt during a write
        start(0, 30, 8'h00);
        repeat (2) @(negedge clk);
        halt_n = 1'b0;
        @(negedge clk);
        check("R9 busy dropped", busy, 0);
        rd_en = 1'b1; rd_addr = 30;
        @(negedge clk);
        rd_en = 1'b0;
        check("R9 no drive in halt", rd_drive, 0);
        @(negedge clk);
        halt_n = 1'b1;
        repeat (PROG_C + 2) @(negedge clk);
        check("R9 no resume", busy, 0);
        rd(30, 8'hFF, "R9 aborted write left byte");
        start(0, 30, 8'hA5);
        wait_idle();
        rd(30, 8'hA5, "R9 normal after halt");

        repeat (3) @(negedge clk);
        check("R10 scoreboard drained", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule